// File: doc/BRIEF.md
# Multi-Input Wake-Up Edge Controller

The controller watches 32 asynchronous wake-up lines. Each line is first synchronized to the block clock. It is then checked for a transition in the direction software has chosen for that line. When such a transition appears on a line whose wake-up enable is set, a sticky per-line pending flag is latched.

The OR of all pending flags drives a wake-up request towards the power manager. A second output raises an interrupt request only for pending lines whose interrupt enable is set. Software configures polarity, wake-up enable and interrupt enable through pairs of 16-bit words on a simple register port, and clears pending flags by writing ones.

The register port has a word index, a write strobe, 16-bit write data and combinational 16-bit read data. In every register pair, the low word holds lines 15..0 (bit n is line n). The high word holds lines 31..16 (bit n is line n+16).

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, every register (indices 0..7) reads 0x0000, and wake_req and irq_req are low.
- R2: Indices 0/1 hold polarity, 2/3 wake-up enable and 4/5 interrupt enable, each low/high word, fully readable and writable. Indices 6/7 read the pending flags low/high.
- R3: A polarity bit of 0 selects a low-to-high transition and 1 a high-to-low transition. Each line passes through two synchronizer flops and one history flop. A change on line n that is driven between clock edges sets pending bit n at the third rising edge after the change.
- R4: A transition on a line whose wake-up enable bit is 0 leaves its pending bit at 0.
- R5: Pending bits are sticky. Writing 1 to a bit at index 6/7 clears it, and writing 0 leaves it unchanged. If a new event and a clear for the same bit meet at one edge, the bit stays set.
- R6: wake_req is high exactly when any pending bit is 1.
- R7: irq_req is high exactly when some pending bit and its interrupt enable bit are both 1. Interrupt enable has no effect on the pending bits.
- R8: A line's event is ignored in the cycle that directly follows a write changing that line's polarity bit.
- R9: Indices 8..15 read 0x0000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_in | input | 32 | Asynchronous wake-up lines |
| reg_addr | input | 4 | Register word index |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| wake_req | output | 1 | Combined wake-up request |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A change on an input line is due at the pending flags, wake_req and irq_req on the third rising edge after it is driven. The bench drives lines on a falling edge, counts three rising edges and samples on the following falling edge. A register write takes effect at the rising edge that samples the strobe. Reads are combinational and are sampled shortly after the index is set. The same-edge set/clear case and the polarity-guard case are timed by counting edges to place the clear write, and the polarity write, in the exact cycle in which the synchronized transition is compared.

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl #(
  parameter int NCH = 32,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] wk_in,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           wake_req,
  output logic           irq_req
);
  localparam int HI = NCH - 1;

  logic [NCH-1:0] sync1, sync2, prev;
  logic [NCH-1:0] pol, wen, ien, pend, guard;
  logic [NCH-1:0] pol_nxt, wen_nxt, ien_nxt, clr, hit;

  always_comb begin
    pol_nxt = pol;
    wen_nxt = wen;
    ien_nxt = ien;
    clr     = '0;
    if (reg_wr) begin
      case (reg_addr)
        4'd0: pol_nxt[DW-1:0]  = reg_wdata;
        4'd1: pol_nxt[HI:DW]   = reg_wdata;
        4'd2: wen_nxt[DW-1:0]  = reg_wdata;
        4'd3: wen_nxt[HI:DW]   = reg_wdata;
        4'd4: ien_nxt[DW-1:0]  = reg_wdata;
        4'd5: ien_nxt[HI:DW]   = reg_wdata;
        4'd6: clr[DW-1:0]      = reg_wdata;
        4'd7: clr[HI:DW]       = reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = pol[DW-1:0];
      4'd1:    reg_rdata = pol[HI:DW];
      4'd2:    reg_rdata = wen[DW-1:0];
      4'd3:    reg_rdata = wen[HI:DW];
      4'd4:    reg_rdata = ien[DW-1:0];
      4'd5:    reg_rdata = ien[HI:DW];
      4'd6:    reg_rdata = pend[DW-1:0];
      4'd7:    reg_rdata = pend[HI:DW];
      default: reg_rdata = '0;
    endcase
  end

  assign hit = ((sync2 & ~prev & ~pol) | (~sync2 & prev & pol)) & wen & ~guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      pol   <= '0;
      wen   <= '0;
      ien   <= '0;
      guard <= '0;
      pend  <= '0;
    end else begin
      sync1 <= wk_in;
      sync2 <= sync1;
      prev  <= sync2;
      guard <= pol_nxt ^ pol;
      pol   <= pol_nxt;
      wen   <= wen_nxt;
      ien   <= ien_nxt;
      pend  <= (pend & ~clr) | hit;
    end
  end

  assign wake_req = |pend;
  assign irq_req  = |(pend & ien);

  a_r4_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(wen)) == '0);

  a_r8_guard_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & $past(guard)) == '0);

  a_r5_sticky_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr)) == '0);

  a_r7_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake_req);

  a_r3_set_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~($past(sync2) ^ $past(prev))) == '0);
endmodule

// File: tb/test_wake_edge_ctrl.sv
module test_wake_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wk_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wake_req, irq_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  wake_edge_ctrl i_wake_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .wk_in(wk_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_req(wake_req), .irq_req(irq_req));

  always #4 clk = ~clk;

  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A,
    32'h5A5A_A5A5, 32'h0000_FFFF, 32'h1234_5678, 32'h0000_0000};
  localparam logic [31:0] CFG_POL = 32'hF0F0_00FF;
  localparam logic [31:0] CFG_WEN = 32'hFFFF_7FFF;
  localparam logic [31:0] CFG_IEN = 32'h8000_0010;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_pend(output logic [31:0] p);
    logic [15:0] lo, hi;
    rd_reg(4'd6, lo); rd_reg(4'd7, hi);
    p = {hi, lo};
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: got %0d expected < 20000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] p, prev_in, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(a[3:0], d);
      chk("R1 reset reg", {16'h0, d}, 32'h0);
    end
    chk("R1 wake_req", {31'h0, wake_req}, 32'h0);
    chk("R1 irq_req", {31'h0, irq_req}, 32'h0);

    // R2 configuration read-back
    wr_reg(4'd0, CFG_POL[15:0]);  wr_reg(4'd1, CFG_POL[31:16]);
    wr_reg(4'd2, CFG_WEN[15:0]);  wr_reg(4'd3, CFG_WEN[31:16]);
    wr_reg(4'd4, CFG_IEN[15:0]);  wr_reg(4'd5, CFG_IEN[31:16]);
    rd_reg(4'd0, d); chk("R2 pol lo", {16'h0, d}, {16'h0, CFG_POL[15:0]});
    rd_reg(4'd1, d); chk("R2 pol hi", {16'h0, d}, {16'h0, CFG_POL[31:16]});
    rd_reg(4'd2, d); chk("R2 wen lo", {16'h0, d}, {16'h0, CFG_WEN[15:0]});
    rd_reg(4'd3, d); chk("R2 wen hi", {16'h0, d}, {16'h0, CFG_WEN[31:16]});
    rd_reg(4'd4, d); chk("R2 ien lo", {16'h0, d}, {16'h0, CFG_IEN[15:0]});
    rd_reg(4'd5, d); chk("R2 ien hi", {16'h0, d}, {16'h0, CFG_IEN[31:16]});
    repeat (2) @(negedge clk);

    // R3 R4 R6 R7 vector walk
    prev_in = '0;
    for (int v = 0; v < NV; v++) begin
      wk_in = VEC[v];
      exp = ((~prev_in & VEC[v] & ~CFG_POL) | (prev_in & ~VEC[v] & CFG_POL)) & CFG_WEN;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd_pend(p);
      chk("R3 not before third edge", p, 32'h0);
      @(posedge clk); @(negedge clk);
      rd_pend(p);
      chk("R3 R4 pending", p, exp);
      chk("R6 wake_req", {31'h0, wake_req}, {31'h0, |exp});
      chk("R7 irq_req", {31'h0, irq_req}, {31'h0, |(exp & CFG_IEN)});
      wr_reg(4'd6, 16'hFFFF); wr_reg(4'd7, 16'hFFFF);
      rd_pend(p);
      chk("R5 clear all", p, 32'h0);
      prev_in = VEC[v];
    end

    // R5 same-edge set and clear, write-zero, write-one
    wr_reg(4'd0, 16'h0000);
    repeat (2) @(negedge clk);
    wk_in[2] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr_reg(4'd6, 16'h0004);
    rd_pend(p); chk("R5 set beats clear", p, 32'h4);
    wr_reg(4'd6, 16'h0000);
    rd_pend(p); chk("R5 write zero keeps", p, 32'h4);
    wr_reg(4'd6, 16'h0004);
    rd_pend(p); chk("R5 write one clears", p, 32'h0);

    // R8 polarity-change guard
    wk_in[3] = 1'b1; settle();
    wr_reg(4'd6, 16'hFFFF);
    wk_in[3] = 1'b0;
    @(posedge clk); @(negedge clk);
    wr_reg(4'd0, 16'h0008);
    settle();
    rd_pend(p); chk("R8 guarded edge ignored", p, 32'h0);
    wk_in[3] = 1'b1; settle();
    rd_pend(p); chk("R8 rise with falling pol", p, 32'h0);
    wk_in[3] = 1'b0; settle();
    rd_pend(p); chk("R8 later fall counted", p, 32'h8);
    wr_reg(4'd6, 16'hFFFF);

    // R9 unused indices
    wr_reg(4'd8, 16'hFFFF);
    wr_reg(4'd15, 16'hFFFF);
    rd_reg(4'd8, d);  chk("R9 idx8 reads 0", {16'h0, d}, 32'h0);
    rd_reg(4'd15, d); chk("R9 idx15 reads 0", {16'h0, d}, 32'h0);
    rd_reg(4'd0, d);  chk("R9 pol lo intact", {16'h0, d}, 32'h0008);
    rd_reg(4'd2, d);  chk("R9 wen lo intact", {16'h0, d}, {16'h0, CFG_WEN[15:0]});
    rd_reg(4'd5, d);  chk("R9 ien hi intact", {16'h0, d}, {16'h0, CFG_IEN[31:16]});
    rd_pend(p);       chk("R9 pending intact", p, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule